// File: doc/BRIEF.md
# Bit-Granular Stream Port

This block lets a processor pack values of any width from 1 to 16 bits into a bit stream held in an internal RAM, and pull values of any such width back out. It keeps two separate contexts. The read context and the write context each have their own 32-bit bit pointer, so one stream can be decoded while another is produced. Both pointers can be read and loaded directly. Every data transfer moves its pointer forward by exactly the number of bits it moved. Pointers never move backwards.

The processor sees a byte-wide register window. The transfer width is not a field. It is chosen by the 16-bit data slot that is accessed: slot k moves k+1 bits. A write is accepted at once into a small buffer and is merged into RAM later, by read-modify-write of the one or two words it covers. A read stalls the processor through a ready signal until the value has been fetched. A read is ordered after all writes already in the buffer.

Top module: `bitstream_port`

## Requirements
- R1: After reset both pointers read as zero, and `cpu_ready` is high while no access is in progress.
- R2: Byte addresses 0–3 hold the read pointer and 4–7 hold the write pointer, little-endian. Each byte can be written and read back directly.
- R3: Write slot k uses a low byte at address 40+2k and a high byte at 41+2k. Writing the low byte only holds it. Writing the high byte commits the least significant k+1 bits of {high,low} and advances the write pointer by k+1. Bits are stored LSB first, from bit address p: RAM word p[11:4] (with default sizes), bit p[3:0] upward.
- R4: Reading the low byte of read slot k (address 8+2k) returns bits [7:0] of the next k+1 stream bits, zero-extended, and advances the read pointer by k+1. Reading address 9+2k then returns bits [15:8] of that value and has no side effect.
- R5: A field that crosses a 16-bit RAM word boundary is written and read correctly.
- R6: A low-byte data read holds `cpu_ready` low for at least one cycle. It returns data that includes every write committed before it. The processor keeps a stalled access unchanged until it completes.
- R7: While the write buffer has room, writes complete without stalling. A high-byte write that finds the buffer full holds `cpu_ready` low until an entry drains. The buffer never overflows.
- R8: Writing any write-pointer byte discards a held low byte, so it counts as zero. Writing any read-pointer byte clears the held high byte, so it reads as zero.
- R9: Writes to read slots change neither pointer nor the RAM. Reads of write slots return zero.
- R10: Committing a field leaves every other stream bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 7 | Byte address in the register window |
| cpu_wdata | input | 8 | Write data byte |
| cpu_rdata | output | 8 | Read data byte, valid when `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes on a clock edge where this and `cpu_sel` are high |

## Verification
The checks assume that the processor keeps address, direction and data stable while an access is stalled. They also assume that it does not touch a pointer in the middle of a stalled read. The bench's single access task holds every request until it sees ready and drops it right after the completing edge, so these conditions always hold. The bench only reads stream bits it has written before. This keeps the comparisons independent of the RAM's contents at power-up.

// File: rtl/bitstream_port.sv
module bitstream_port #(
  parameter int MEM_WORDS  = 256,
  parameter int FIFO_DEPTH = 4
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_sel,
  input  logic       cpu_we,
  input  logic [6:0] cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       cpu_ready
);
  localparam int AW = $clog2(MEM_WORDS);
  localparam int PW = AW + 4;
  localparam int FW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_F0, S_F1, S_F2, S_WB0, S_WB1, S_DONE} st_t;

  logic [31:0] rd_ptr, wr_ptr;
  logic [7:0]  lo_hold, hi_hold;

  logic [PW-1:0] f_bit [FIFO_DEPTH];
  logic [4:0]    f_w   [FIFO_DEPTH];
  logic [15:0]   f_val [FIFO_DEPTH];
  logic [FW-1:0] f_wp, f_rp;
  logic [FW:0]   f_cnt;

  logic [15:0] mem [MEM_WORDS];
  logic [AW-1:0] maddr;
  logic [15:0] q, w0, w1;
  st_t st;
  logic [PW-1:0] e_bit;
  logic [4:0]    e_w;
  logic [15:0]   e_val;
  logic          e_wr;

  wire is_ptr   = cpu_addr < 7'd8;
  wire is_rdwin = (cpu_addr >= 7'd8)  && (cpu_addr < 7'd40);
  wire is_wrwin = (cpu_addr >= 7'd40) && (cpu_addr < 7'd72);
  wire [3:0] ridx = 4'((cpu_addr - 7'd8) >> 1);
  wire [3:0] widx = 4'((cpu_addr - 7'd40) >> 1);
  wire [4:0] rwidth = {1'b0, ridx} + 5'd1;
  wire [4:0] wwidth = {1'b0, widx} + 5'd1;

  wire rd_req    = cpu_sel && !cpu_we && is_rdwin && !cpu_addr[0];
  wire wr_commit = cpu_sel && cpu_we && is_wrwin && cpu_addr[0];
  wire fifo_full = f_cnt == (FW+1)'(FIFO_DEPTH);
  wire push      = wr_commit && !fifo_full;
  wire pop       = (st == S_IDLE) && (f_cnt != '0);
  wire ptr_wr    = cpu_sel && cpu_we && is_ptr;

  assign cpu_ready = rd_req ? (st == S_DONE) : !(wr_commit && fifo_full);

  wire [3:0]  off   = e_bit[3:0];
  wire [15:0] wmask = 16'hFFFF >> (5'd16 - e_w);
  wire [31:0] pair  = {w1, w0};
  wire [31:0] fmask = {16'h0, wmask} << off;
  wire [31:0] merged = (pair & ~fmask) | ({16'h0, e_val & wmask} << off);
  wire [15:0] rd_val = 16'(pair >> off) & wmask;

  always_comb begin
    cpu_rdata = 8'h00;
    if (is_ptr)
      cpu_rdata = cpu_addr[2] ? wr_ptr[{cpu_addr[1:0], 3'b000} +: 8]
                              : rd_ptr[{cpu_addr[1:0], 3'b000} +: 8];
    else if (is_rdwin)
      cpu_rdata = cpu_addr[0] ? hi_hold : rd_val[7:0];
  end

  always_ff @(posedge clk) begin
    q <= mem[maddr];
    if (st == S_WB0) mem[maddr] <= merged[15:0];
    if (st == S_WB1) mem[maddr] <= merged[31:16];
  end

  always_ff @(posedge clk) begin
    if (push) begin
      f_bit[f_wp] <= wr_ptr[PW-1:0];
      f_w[f_wp]   <= wwidth;
      f_val[f_wp] <= {cpu_wdata, lo_hold};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      lo_hold <= '0;
      hi_hold <= '0;
      f_wp    <= '0;
      f_rp    <= '0;
      f_cnt   <= '0;
      st      <= S_IDLE;
      maddr   <= '0;
      w0      <= '0;
      w1      <= '0;
      e_bit   <= '0;
      e_w     <= 5'd1;
      e_val   <= '0;
      e_wr    <= 1'b0;
    end else begin
      if (ptr_wr) begin
        if (cpu_addr[2]) begin
          wr_ptr[{cpu_addr[1:0], 3'b000} +: 8] <= cpu_wdata;
          lo_hold <= '0;
        end else begin
          rd_ptr[{cpu_addr[1:0], 3'b000} +: 8] <= cpu_wdata;
          hi_hold <= '0;
        end
      end
      if (cpu_sel && cpu_we && is_wrwin && !cpu_addr[0]) lo_hold <= cpu_wdata;
      if (push) begin
        wr_ptr <= wr_ptr + 32'(wwidth);
        f_wp   <= (f_wp == FW'(FIFO_DEPTH-1)) ? '0 : f_wp + 1'b1;
      end
      if (pop) f_rp <= (f_rp == FW'(FIFO_DEPTH-1)) ? '0 : f_rp + 1'b1;
      f_cnt <= f_cnt + (FW+1)'(push) - (FW+1)'(pop);

      case (st)
        S_IDLE: begin
          if (pop) begin
            e_bit <= f_bit[f_rp];
            e_w   <= f_w[f_rp];
            e_val <= f_val[f_rp];
            e_wr  <= 1'b1;
            maddr <= f_bit[f_rp][PW-1:4];
            st    <= S_F0;
          end else if (rd_req) begin
            e_bit <= rd_ptr[PW-1:0];
            e_w   <= rwidth;
            e_wr  <= 1'b0;
            maddr <= rd_ptr[PW-1:4];
            st    <= S_F0;
          end
        end
        S_F0: begin
          maddr <= maddr + 1'b1;
          st    <= S_F1;
        end
        S_F1: begin
          w0 <= q;
          st <= S_F2;
        end
        S_F2: begin
          w1 <= q;
          if (e_wr) begin
            maddr <= e_bit[PW-1:4];
            st    <= S_WB0;
          end else begin
            st <= S_DONE;
          end
        end
        S_WB0: begin
          maddr <= maddr + 1'b1;
          st    <= S_WB1;
        end
        S_WB1: st <= S_IDLE;
        S_DONE: begin
          if (rd_req) begin
            hi_hold <= rd_val[15:8];
            rd_ptr  <= rd_ptr + 32'(e_w);
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitstream_port_chk.sv
module bitstream_port_chk #(
  parameter int FIFO_DEPTH = 4
)(
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic        we,
  input logic [6:0]  addr,
  input logic [7:0]  wdata,
  input logic        ready,
  input logic [31:0] rd_ptr,
  input logic [31:0] wr_ptr,
  input logic [7:0]  lo_hold,
  input logic [7:0]  hi_hold,
  input logic [((FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1):0] fifo_cnt
);
  wire rdwin = (addr >= 7'd8) && (addr < 7'd40);
  wire wrwin = (addr >= 7'd40) && (addr < 7'd72);
  wire rdlo  = rdwin && !addr[0];
  wire [31:0] rsz = 32'(4'((addr - 7'd8) >> 1)) + 32'd1;
  wire [31:0] wsz = 32'(4'((addr - 7'd40) >> 1)) + 32'd1;

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sel && we && ready && addr == 7'd0 |=> rd_ptr[7:0] == $past(wdata)); // R2
  AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    sel && we && ready && wrwin && addr[0] |=> wr_ptr == $past(wr_ptr) + $past(wsz)); // R3
  AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    sel && !we && ready && rdlo |=> rd_ptr == $past(rd_ptr) + $past(rsz)); // R4
  AST_RD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    sel && !we && ready && rdlo |=> !(sel && !we && rdlo && ready)); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sel && !ready |=> sel && $stable(addr) && $stable(we) && $stable(wdata)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= ($bits(fifo_cnt))'(FIFO_DEPTH)); // R7
  AST_WR_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    sel && we && fifo_cnt < ($bits(fifo_cnt))'(FIFO_DEPTH) |-> ready); // R7
  AST_LO_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    sel && we && ready && addr >= 7'd4 && addr < 7'd8 |=> lo_hold == 8'h00); // R8
  AST_HI_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    sel && we && ready && addr < 7'd4 |=> hi_hold == 8'h00); // R8
  AST_RDWIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    sel && we && rdwin |=> $stable(rd_ptr) && $stable(wr_ptr)); // R9
endmodule

bind bitstream_port bitstream_port_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(cpu_sel), .we(cpu_we), .addr(cpu_addr),
  .wdata(cpu_wdata), .ready(cpu_ready), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
  .lo_hold(lo_hold), .hi_hold(hi_hold), .fifo_cnt(f_cnt)
);

// File: tb/tb_bitstream_port.sv
module tb_bitstream_port;
  localparam int MEM_WORDS = 256;
  localparam int DEPTH     = 4;
  localparam int NB        = MEM_WORDS * 16;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, we = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic ready;

  always #4 clk = ~clk;

  bitstream_port #(.MEM_WORDS(MEM_WORDS), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(sel), .cpu_we(we), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_rdata(rdata), .cpu_ready(ready));

  int total = 0, bad = 0;
  logic [NB-1:0] model = '0;
  logic [31:0] m_rp = '0, m_wp = '0;
  int last_wait = 0;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic access(input logic w, input logic [6:0] a, input logic [7:0] d, output int waits);
    @(negedge clk);
    sel = 1'b1; we = w; addr = a; wdata = d; waits = 0;
    #1;
    while (!ready) begin
      @(negedge clk); #1; waits++;
    end
    @(posedge clk); #1;
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, output int waits);
    access(1'b1, a, d, waits);
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] expv, input string tag);
    exp_t e;
    e.v = expv; e.tag = tag;
    exp_q.push_back(e);
    access(1'b0, a, 8'h00, last_wait);
  endtask

  function automatic logic [15:0] mget(input logic [31:0] p, input int w);
    logic [15:0] r = '0;
    for (int b = 0; b < w; b++) r[b] = model[(p + 32'(b)) % 32'(NB)];
    return r;
  endfunction

  task automatic set_ptr(input int ctx, input logic [31:0] v);
    int wt;
    for (int i = 0; i < 4; i++) wr(7'(ctx*4 + i), v[8*i +: 8], wt);
    if (ctx == 0) m_rp = v; else m_wp = v;
  endtask

  task automatic chk_ptr(input int ctx, input logic [31:0] v, input string tag);
    for (int i = 0; i < 4; i++) rd(7'(ctx*4 + i), v[8*i +: 8], tag);
  endtask

  task automatic put(input int w, input logic [15:0] v, output int waits);
    int wt;
    wr(7'(40 + 2*(w-1)), v[7:0], wt);
    wr(7'(41 + 2*(w-1)), v[15:8], waits);
    for (int b = 0; b < w; b++) model[(m_wp + 32'(b)) % 32'(NB)] = v[b];
    m_wp = m_wp + 32'(w);
  endtask

  task automatic get(input int w, input string tag);
    logic [15:0] v;
    v = mget(m_rp, w);
    rd(7'(8 + 2*(w-1)), v[7:0], tag);
    m_rp = m_rp + 32'(w);
    check(last_wait > 0, "R6 read-lo stalls", 32'(last_wait), 32'd1);
    rd(7'(9 + 2*(w-1)), v[15:8], tag);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial forever begin
    exp_t e;
    @(negedge clk); #2;
    if (sel && !we && ready) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R4 unexpected read actual=%0h expected=none", rdata);
      end else begin
        e = exp_q.pop_front();
        check(rdata === e.v, e.tag, 32'(rdata), 32'(e.v));
      end
    end
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int wt;
    bit stalled;
    logic [15:0] vals [10];
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    check(ready === 1'b1, "R1 ready idle", 32'(ready), 32'd1);
    chk_ptr(0, 32'd0, "R1 read ptr reset");
    chk_ptr(1, 32'd0, "R1 write ptr reset");

    set_ptr(0, 32'h12345678);
    chk_ptr(0, 32'h12345678, "R2 read ptr bytes");
    set_ptr(1, 32'hCAFE0011);
    chk_ptr(1, 32'hCAFE0011, "R2 write ptr bytes");
    set_ptr(0, 32'd0);
    set_ptr(1, 32'd0);

    for (int i = 0; i < 32; i++) put(16, 16'(i * 16'h1357) ^ 16'hA5C3, wt);
    chk_ptr(1, 32'd512, "R3 write ptr advance");

    for (int i = 0; i < 40; i++) get((i % 16) + 1, "R4 R5 mixed width read");
    chk_ptr(0, m_rp, "R4 read ptr advance");

    set_ptr(1, 32'd300);
    put(3, 16'hFFFD, wt);
    put(7, 16'h1234, wt);
    put(16, 16'hBEEF, wt);
    put(5, 16'h7777, wt);
    put(11, 16'hF00F, wt);
    put(13, 16'h5A5A, wt);
    set_ptr(0, 32'd290);
    for (int i = 0; i < 5; i++) get(16, "R10 R6 R3 R5 merge and order");

    set_ptr(1, 32'd700);
    wr(7'd70, 8'hFF, wt);
    wr(7'd4, 8'hBC, wt);
    wr(7'd71, 8'h12, wt);
    for (int b = 0; b < 16; b++) model[700 + b] = (16'h1200 >> b) & 1'b1;
    m_wp = 32'd716;
    set_ptr(0, 32'd700);
    get(16, "R8 low byte discarded");

    set_ptr(0, 32'd0);
    rd(7'd38, mget(0, 16) & 8'hFF, "R8 read lo");
    m_rp = 32'd16;
    wr(7'd0, 8'h00, wt);
    m_rp = 32'd0;
    rd(7'd39, 8'h00, "R8 high byte cleared");

    wr(7'd8, 8'hAA, wt);
    wr(7'd9, 8'h55, wt);
    chk_ptr(0, m_rp, "R9 read ptr unchanged");
    chk_ptr(1, m_wp, "R9 write ptr unchanged");
    rd(7'd40, 8'h00, "R9 write slot reads zero");
    rd(7'd41, 8'h00, "R9 write slot reads zero");
    get(8, "R9 stream unchanged");

    repeat (30) @(posedge clk);
    set_ptr(1, 32'd1000);
    stalled = 0;
    for (int i = 0; i < 10; i++) begin
      vals[i] = 16'(16'hC3A5 + i * 16'h0F1F);
      put(4 + i, vals[i], wt);
      if (i < 4) check(wt == 0, "R7 no stall with room", 32'(wt), 32'd0);
      if (wt > 0) stalled = 1;
    end
    check(stalled, "R7 full buffer stalls", 32'(stalled), 32'd1);
    set_ptr(0, 32'd1000);
    for (int i = 0; i < 10; i++) get(4 + i, "R7 burst data intact");

    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R4 all reads observed", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule